// File: doc/BRIEF.md
# In-System Programming Command Front End

This block is the target side of a three-wire serial programming link. A host drives a serial clock and a data line into the chip and reads a reply line back. The block runs on the system clock and oversamples the serial clock through synchronizers. It gathers the incoming bits, most significant first, into fixed four-byte instructions. It decodes each instruction into one request for the memory subsystem behind it, which answers through a plain valid/ready handshake with a read-data bus.

The link is only live while the programming-mode input `prog_mode_ni` is held low. Raising that input clears framing and drops any armed state. Within a session, the host first has to send the enable instruction. Until that enable arrives, every other instruction runs through its four bytes and is discarded. While the third byte of any instruction is shifting in, the reply line carries the second byte back to the host. The host uses this echo to confirm that the bit and byte framing is aligned. For read instructions, the fourth reply byte carries the data fetched from memory.

Top module: `isp_cmd_front`

## Requirements
- R1: Data on `mosi_i` is taken on each rising edge of `sck_i`, most significant bit first. Every 32 rising edges form one instruction of four bytes, and each instruction yields at most one request.
- R2: `miso_o` changes only after a falling edge of `sck_i`, most significant bit first. The first bit of each reply byte appears after the falling edge that follows the last bit of the previous byte.
- R3: During the third byte of every instruction, `miso_o` returns the second byte received in that instruction.
- R4: Before an enable instruction (first byte 0xAC, second byte 0x53) has completed in the current session, no request is issued and the fourth reply byte is 0x00.
- R5: While `prog_mode_ni` is high, the bit and byte counters, the enable state and any pending request are cleared, and `miso_o` is 0.
- R6: Read instructions issue a request after the third byte, and the returned `rd_data_i` is shifted out as the fourth reply byte. The kind codes are: 1 program read (0x20 low byte, 0x28 high byte, word address from the low PROG_AW bits of bytes 2:3); 4 EEPROM read (0xA0, address from the low EE_AW bits of bytes 2:3); 7 fuse read (0x50 0x00); 9 fuse-high read (0x58 0x08); 11 lock read (0x58 0x00); 13 signature read (0x30); 14 calibration read (0x38). For kinds 13 and 14 the address is the low 2 bits of byte 3.
- R7: Write instructions issue their request at the end of the fourth byte, and the data field carries byte 4. The kind codes are: 2 page load (0x40 low byte, 0x48 high byte, address from the low PAGE_W bits of byte 3); 3 page write (0x4C, program address with the low PAGE_W bits cleared); 5 EEPROM write (0xC0); 6 chip erase (0xAC, second byte 100x_xxxx); 8 fuse write (0xAC 0xA0); 10 fuse-high write (0xAC 0xA8). `req_hi_o` gives the byte half (opcode bit 3) for kinds 1 and 2 and is 0 for all other kinds.
- R8: A lock write (kind 12, 0xAC with second byte 111x_xxxx) sends data whose two upper bits are forced to 1 and whose lower six bits come from byte 4.
- R9: An opcode that matches no encoding issues no request, and its fourth reply byte is 0x00.
- R10: A request stays asserted with stable kind, address and data until `req_ready_i` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_mode_ni | input | 1 | Low selects programming mode; high clears the link |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| req_valid_o | output | 1 | Memory request pending |
| req_kind_o | output | 4 | Request kind code (see R6 to R8) |
| req_addr_o | output | 16 | Request address |
| req_hi_o | output | 1 | High byte selected for program memory kinds |
| req_data_o | output | 8 | Write data |
| req_ready_i | input | 1 | Memory accepts the request |
| rd_data_i | input | 8 | Read data, taken with the accepted read request |

## Verification
The bench builds the block with its defaults: a 12-bit program word address, a 9-bit EEPROM address, a 5-bit page index and two synchronizer stages. With these values the bench can observe page-write masking of the low five address bits, truncation of wide addresses in reads, and both byte halves. The serial clock phases last four system clocks, which exercises the shortest margin between the third-byte read request and the loading of the fourth reply byte. A memory model that holds ready low shows that a write request stays pending and unchanged.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    K_NONE     = 4'd0,
    K_PROG_RD  = 4'd1,
    K_PAGE_LD  = 4'd2,
    K_PAGE_WR  = 4'd3,
    K_EE_RD    = 4'd4,
    K_EE_WR    = 4'd5,
    K_ERASE    = 4'd6,
    K_FUSE_RD  = 4'd7,
    K_FUSE_WR  = 4'd8,
    K_FUSEH_RD = 4'd9,
    K_FUSEH_WR = 4'd10,
    K_LOCK_RD  = 4'd11,
    K_LOCK_WR  = 4'd12,
    K_SIG_RD   = 4'd13,
    K_CAL_RD   = 4'd14
  } req_kind_e;
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);
  logic [STAGES:0]   sck_q;
  logic [STAGES-1:0] mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[STAGES-1:0], sck_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
    end
  end

  // mosi_q[STAGES-1] is aligned with sck_q[STAGES-1]
  assign rise_o = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign fall_o = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign mosi_o = mosi_q[STAGES-1];
endmodule

// File: rtl/isp_frame.sv
module isp_frame import isp_pkg::*; #(
  parameter int BYTES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic                          rise_i,
  input  logic                          fall_i,
  input  logic                          mosi_i,
  input  logic [BYTE_W-1:0]             resp_i,
  output logic [BYTES-1:0][BYTE_W-1:0]  bytes_o,
  output logic [$clog2(BYTES)-1:0]      byte_idx_o,
  output logic                          rd_point_o,
  output logic                          frame_done_o,
  output logic                          miso_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam int IW = $clog2(BYTES);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [BYTE_W-1:0] rx_nxt;

  assign rx_nxt = {rx_q[BYTE_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0; byte_idx_o <= '0; rx_q <= '0; tx_q <= '0;
      bytes_o <= '0; rd_point_o <= 1'b0; frame_done_o <= 1'b0; miso_o <= 1'b0;
    end else if (clear_i) begin
      bit_cnt <= '0; byte_idx_o <= '0; rx_q <= '0; tx_q <= '0;
      rd_point_o <= 1'b0; frame_done_o <= 1'b0; miso_o <= 1'b0;
    end else begin
      rd_point_o   <= 1'b0;
      frame_done_o <= 1'b0;
      if (rise_i) begin
        rx_q    <= rx_nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CW'(BYTE_W - 1)) begin
          bytes_o[byte_idx_o] <= rx_nxt;
          byte_idx_o          <= byte_idx_o + 1'b1;
          if (byte_idx_o == IW'(BYTES - 2)) rd_point_o   <= 1'b1;
          if (byte_idx_o == IW'(BYTES - 1)) frame_done_o <= 1'b1;
        end
      end
      if (fall_i) begin
        if (bit_cnt == '0) begin
          miso_o <= resp_i[BYTE_W-1];
          tx_q   <= {resp_i[BYTE_W-2:0], 1'b0};
        end else begin
          miso_o <= tx_q[BYTE_W-1];
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  a_r5_clear_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (bit_cnt == '0) && (byte_idx_o == '0) && !miso_o);
  a_r2_miso_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !clear_i) |=> $stable(miso_o));
  a_r1_frame_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (byte_idx_o == '0));
endmodule

// File: rtl/isp_decode.sv
module isp_decode import isp_pkg::*; #(
  parameter int PROG_AW = 12,
  parameter int EE_AW   = 9,
  parameter int PAGE_W  = 5
) (
  input  logic [BYTE_W-1:0] op_i,
  input  logic [BYTE_W-1:0] b1_i,
  input  logic [BYTE_W-1:0] b2_i,
  input  logic [BYTE_W-1:0] b3_i,
  output req_kind_e         kind_o,
  output logic              is_rd_o,
  output logic              is_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              hi_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam logic [ADDR_W-1:0] PROG_MASK = ADDR_W'((1 << PROG_AW) - 1);
  localparam logic [ADDR_W-1:0] EE_MASK   = ADDR_W'((1 << EE_AW) - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);

  logic [ADDR_W-1:0] wide;
  assign wide = {b1_i, b2_i};

  always_comb begin
    kind_o  = K_NONE;
    is_en_o = 1'b0;
    addr_o  = '0;
    hi_o    = 1'b0;
    data_o  = '0;
    if (op_i == 8'hAC) begin
      if (b1_i == 8'h53)              is_en_o = 1'b1;
      else if (b1_i[7:5] == 3'b100)   kind_o = K_ERASE;
      else if (b1_i[7:5] == 3'b111) begin
        kind_o = K_LOCK_WR; data_o = {2'b11, b3_i[5:0]};
      end
      else if (b1_i == 8'hA0) begin kind_o = K_FUSE_WR;  data_o = b3_i; end
      else if (b1_i == 8'hA8) begin kind_o = K_FUSEH_WR; data_o = b3_i; end
    end else if (op_i == 8'h20 || op_i == 8'h28) begin
      kind_o = K_PROG_RD; hi_o = op_i[3]; addr_o = wide & PROG_MASK;
    end else if (op_i == 8'h40 || op_i == 8'h48) begin
      kind_o = K_PAGE_LD; hi_o = op_i[3]; data_o = b3_i;
      addr_o = {8'h00, b2_i} & PAGE_MASK;
    end else if (op_i == 8'h4C) begin
      kind_o = K_PAGE_WR; addr_o = wide & PROG_MASK & ~PAGE_MASK;
    end else if (op_i == 8'hA0) begin
      kind_o = K_EE_RD; addr_o = wide & EE_MASK;
    end else if (op_i == 8'hC0) begin
      kind_o = K_EE_WR; addr_o = wide & EE_MASK; data_o = b3_i;
    end else if (op_i == 8'h30) begin
      kind_o = K_SIG_RD; addr_o = {14'd0, b2_i[1:0]};
    end else if (op_i == 8'h38) begin
      kind_o = K_CAL_RD; addr_o = {14'd0, b2_i[1:0]};
    end else if (op_i == 8'h50 && b1_i == 8'h00) begin
      kind_o = K_FUSE_RD;
    end else if (op_i == 8'h58 && b1_i == 8'h00) begin
      kind_o = K_LOCK_RD;
    end else if (op_i == 8'h58 && b1_i == 8'h08) begin
      kind_o = K_FUSEH_RD;
    end
  end

  always_comb begin
    unique case (kind_o)
      K_PROG_RD, K_EE_RD, K_FUSE_RD, K_FUSEH_RD,
      K_LOCK_RD, K_SIG_RD, K_CAL_RD: is_rd_o = 1'b1;
      default:                       is_rd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/isp_cmd_front.sv
module isp_cmd_front import isp_pkg::*; #(
  parameter int PROG_AW     = 12,
  parameter int EE_AW       = 9,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_mode_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              req_valid_o,
  output logic [3:0]        req_kind_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_hi_o,
  output logic [7:0]        req_data_o,
  input  logic              req_ready_i,
  input  logic [7:0]        rd_data_i
);
  localparam int BYTES = 4;

  logic rise, fall, mosi_s, rd_point, frame_done;
  logic [BYTES-1:0][BYTE_W-1:0] bytes;
  logic [$clog2(BYTES)-1:0]     byte_idx;
  logic [BYTE_W-1:0]            resp, rd_resp_q;
  logic                         en_q, is_rd_q;

  req_kind_e         dec_kind;
  logic              dec_rd, dec_en, dec_hi;
  logic [ADDR_W-1:0] dec_addr;
  logic [BYTE_W-1:0] dec_data;

  isp_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .mosi_i,
    .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s)
  );

  // byte 3 echoes byte 2; byte 4 carries read data
  always_comb begin
    unique case (byte_idx)
      2'd2:    resp = bytes[1];
      2'd3:    resp = rd_resp_q;
      default: resp = '0;
    endcase
  end

  isp_frame #(.BYTES(BYTES)) u_frame (
    .clk_i, .rst_ni, .clear_i(prog_mode_ni), .rise_i(rise), .fall_i(fall),
    .mosi_i(mosi_s), .resp_i(resp), .bytes_o(bytes), .byte_idx_o(byte_idx),
    .rd_point_o(rd_point), .frame_done_o(frame_done), .miso_o
  );

  isp_decode #(.PROG_AW(PROG_AW), .EE_AW(EE_AW), .PAGE_W(PAGE_W)) u_dec (
    .op_i(bytes[0]), .b1_i(bytes[1]), .b2_i(bytes[2]), .b3_i(bytes[3]),
    .kind_o(dec_kind), .is_rd_o(dec_rd), .is_en_o(dec_en),
    .addr_o(dec_addr), .hi_o(dec_hi), .data_o(dec_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; is_rd_q <= 1'b0; rd_resp_q <= '0;
      req_valid_o <= 1'b0; req_kind_o <= '0; req_addr_o <= '0;
      req_hi_o <= 1'b0; req_data_o <= '0;
    end else if (prog_mode_ni) begin
      en_q <= 1'b0; req_valid_o <= 1'b0; rd_resp_q <= '0;
    end else begin
      if (req_valid_o && req_ready_i) begin
        req_valid_o <= 1'b0;
        if (is_rd_q) rd_resp_q <= rd_data_i;
      end
      if (rd_point) begin
        rd_resp_q <= '0;
        if (en_q && dec_rd && !req_valid_o) begin
          req_valid_o <= 1'b1; is_rd_q <= 1'b1;
          req_kind_o <= dec_kind; req_addr_o <= dec_addr;
          req_hi_o <= dec_hi; req_data_o <= dec_data;
        end
      end
      if (frame_done) begin
        if (dec_en) en_q <= 1'b1;
        if (en_q && dec_kind != K_NONE && !dec_rd && !req_valid_o) begin
          req_valid_o <= 1'b1; is_rd_q <= 1'b0;
          req_kind_o <= dec_kind; req_addr_o <= dec_addr;
          req_hi_o <= dec_hi; req_data_o <= dec_data;
        end
      end
    end
  end

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !prog_mode_ni) |=>
      (req_valid_o && $stable(req_kind_o) && $stable(req_addr_o) && $stable(req_data_o)));
  a_r4_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> en_q);
  a_r5_mode_drops_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_mode_ni |=> (!req_valid_o && !en_q));
endmodule

// File: tb/isp_cmd_front_bench.sv
module isp_cmd_front_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic prog_mode_ni = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, miso;
  logic req_valid, req_hi, req_ready = 1'b1;
  logic [3:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_data, rd_data;

  always #2.5 clk = ~clk;

  isp_cmd_front u_isp_cmd_front (
    .clk_i(clk), .rst_ni, .prog_mode_ni, .sck_i(sck), .mosi_i(mosi), .miso_o(miso),
    .req_valid_o(req_valid), .req_kind_o(req_kind), .req_addr_o(req_addr),
    .req_hi_o(req_hi), .req_data_o(req_data), .req_ready_i(req_ready), .rd_data_i(rd_data)
  );

  // memory model
  function automatic logic [7:0] mem_val(logic [15:0] a, logic [3:0] k, logic h);
    return a[7:0] ^ {4'h0, k} ^ {h, 7'b0};
  endfunction
  assign rd_data = mem_val(req_addr, req_kind, req_hi);

  int n_chk = 0, n_fail = 0, mon_cnt = 0;
  logic [3:0] mon_kind; logic [15:0] mon_addr; logic mon_hi; logic [7:0] mon_data;

  always @(negedge clk) if (req_valid && req_ready) begin
    mon_cnt++; mon_kind = req_kind; mon_addr = req_addr; mon_hi = req_hi; mon_data = req_data;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(logic b, output logic got, inout logic stable_ok);
    logic m1;
    mosi = b;
    wait_clk(4);
    got = miso;
    sck = 1'b1;
    wait_clk(4);
    m1 = miso;
    if (m1 !== got) stable_ok = 1'b0;
    sck = 1'b0;
  endtask

  task automatic send_frame(logic [31:0] frm, output logic [31:0] rx, output logic stable_ok);
    stable_ok = 1'b1;
    for (int i = 31; i >= 0; i--) send_bit(frm[i], rx[i], stable_ok);
    wait_clk(4);
  endtask

  typedef struct packed {
    logic [31:0] frm;
    logic        has_req;
    logic [3:0]  kind;
    logic [15:0] addr;
    logic        hi;
    logic [7:0]  data;
    logic        rd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h20012300, 1'b1, 4'd1,  16'h0123, 1'b0, 8'h00, 1'b1},
    '{32'h28FABC00, 1'b1, 4'd1,  16'h0ABC, 1'b1, 8'h00, 1'b1},
    '{32'h40001F5A, 1'b1, 4'd2,  16'h001F, 1'b0, 8'h5A, 1'b0},
    '{32'h480043A5, 1'b1, 4'd2,  16'h0003, 1'b1, 8'hA5, 1'b0},
    '{32'h4C07E500, 1'b1, 4'd3,  16'h07E0, 1'b0, 8'h00, 1'b0},
    '{32'hA003FF00, 1'b1, 4'd4,  16'h01FF, 1'b0, 8'h00, 1'b1},
    '{32'hC0001077, 1'b1, 4'd5,  16'h0010, 1'b0, 8'h77, 1'b0},
    '{32'hAC9F0000, 1'b1, 4'd6,  16'h0000, 1'b0, 8'h00, 1'b0},
    '{32'h50000000, 1'b1, 4'd7,  16'h0000, 1'b0, 8'h00, 1'b1},
    '{32'hACA000E1, 1'b1, 4'd8,  16'h0000, 1'b0, 8'hE1, 1'b0},
    '{32'h58080000, 1'b1, 4'd9,  16'h0000, 1'b0, 8'h00, 1'b1},
    '{32'hACA800D9, 1'b1, 4'd10, 16'h0000, 1'b0, 8'hD9, 1'b0},
    '{32'h58000000, 1'b1, 4'd11, 16'h0000, 1'b0, 8'h00, 1'b1},
    '{32'hACE00005, 1'b1, 4'd12, 16'h0000, 1'b0, 8'hC5, 1'b0},
    '{32'h30000200, 1'b1, 4'd13, 16'h0002, 1'b0, 8'h00, 1'b1},
    '{32'h38000100, 1'b1, 4'd14, 16'h0001, 1'b0, 8'h00, 1'b1},
    '{32'h77123456, 1'b0, 4'd0,  16'h0000, 1'b0, 8'h00, 1'b0},
    '{32'hAC530000, 1'b0, 4'd0,  16'h0000, 1'b0, 8'h00, 1'b0}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rx;
    logic st, dummy;
    int c0;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(3);
    chk("R5 reset miso", miso, 0);
    chk("R5 reset req_valid", req_valid, 0);
    prog_mode_ni = 1'b0;
    wait_clk(4);

    // R4: read before enable is dropped
    c0 = mon_cnt;
    send_frame(32'h30000100, rx, st);
    chk("R4 no request before enable", mon_cnt - c0, 0);
    chk("R4 reply byte4 before enable", rx[7:0], 8'h00);

    // enable, R3 echo
    c0 = mon_cnt;
    send_frame(32'hAC530000, rx, st);
    chk("R3 echo of 0x53", rx[15:8], 8'h53);
    chk("R4 enable issues no request", mon_cnt - c0, 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      if (!VECS[v].has_req) tag = "R9";
      else if (VECS[v].kind == 4'd12) tag = "R8";
      else if (VECS[v].rd) tag = "R6";
      else tag = "R7";
      c0 = mon_cnt;
      send_frame(VECS[v].frm, rx, st);
      chk("R1 one request per frame", mon_cnt - c0, {31'd0, VECS[v].has_req});
      chk("R3 echo", rx[15:8], {24'd0, VECS[v].frm[23:16]});
      chk("R2 miso stable while sck high", st, 1);
      chk({tag, " reply byte4"}, rx[7:0],
          VECS[v].rd ? mem_val(VECS[v].addr, VECS[v].kind, VECS[v].hi) : 8'h00);
      if (VECS[v].has_req) begin
        chk({tag, " kind"}, mon_kind, VECS[v].kind);
        chk({tag, " addr"}, mon_addr, VECS[v].addr);
        chk({tag, " hi"}, mon_hi, VECS[v].hi);
        chk({tag, " data"}, mon_data, VECS[v].data);
      end
    end

    // R10: request held while ready low
    req_ready = 1'b0;
    c0 = mon_cnt;
    send_frame(32'hC0002011, rx, st);
    chk("R10 pending valid", req_valid, 1);
    wait_clk(10);
    chk("R10 still valid", req_valid, 1);
    chk("R10 kind stable", req_kind, 4'd5);
    chk("R10 addr stable", req_addr, 16'h0020);
    chk("R10 data stable", req_data, 8'h11);
    req_ready = 1'b1;
    wait_clk(2);
    chk("R10 accepted once", mon_cnt - c0, 1);
    chk("R10 drops after ready", req_valid, 0);

    // R5: partial frame then mode exit clears framing and enable
    st = 1'b1;
    for (int i = 0; i < 12; i++) send_bit(1'b1, dummy, st);
    prog_mode_ni = 1'b1;
    wait_clk(4);
    chk("R5 miso cleared", miso, 0);
    prog_mode_ni = 1'b0;
    wait_clk(4);
    c0 = mon_cnt;
    send_frame(32'h30000000, rx, st);
    chk("R5 enable lost after mode exit", mon_cnt - c0, 0);
    send_frame(32'hAC530000, rx, st);
    chk("R5 framing realigned echo", rx[15:8], 8'h53);
    c0 = mon_cnt;
    send_frame(32'h30000300, rx, st);
    chk("R6 signature after re-enable", mon_cnt - c0, 1);
    chk("R6 signature reply", rx[7:0], mem_val(16'h0003, 4'd13, 1'b0));

    finish_run();
  end
endmodule